// File: doc/BRIEF.md
# Parity-Preserving Peres and TR Function Unit

This combinational unit produces either the Peres mapping or the TR mapping of three input bits. Neither mapping keeps the parity of its lines, so each is rebuilt from gates that do: the double Feynman gate and the Fredkin gate. Each function gets its own chain of three such gates. A chain takes two constant-zero ancilla lines inside the block and gives off two garbage lines. Both chains always run side by side, and a one-bit select picks which chain drives the three primary outputs. The garbage lines of both chains are visible as outputs.

Every gate instance has a checker. It compares the parity of the gate's inputs with the parity of its outputs, and the mismatch bits are collected in a per-gate map and a single fault flag. A fault-injection vector can flip any single output line of any gate, so the detection path can be exercised from the ports. Within a chain, a line indexed by `(chain*3 + gate)*3 + line` is flipped by bit `inj_in` of that number. The gate order in a chain is: first double Feynman = 0, Fredkin = 1, second double Feynman = 2. Output lines of a gate are numbered in port order. The select can also use the TR chain on its own as a one-bit subtractor.

Top module: `peres_tr_pp`

## Requirements
- R1: With `sel_tr`=0 and no injection, `y_out` = {R, Q, P} with P = a, Q = a xor b, R = (a and b) xor c, for all eight input vectors.
- R2: With `sel_tr`=1 and no injection, `y_out` = {R, Q, P} with P = a, Q = a xor b, R = (a and not b) xor c, for all eight input vectors.
- R3: With `sel_tr`=1 and `c_in`=0, `y_out[1]` is the difference bit and `y_out[2]` is the borrow bit of the one-bit subtraction b minus a.
- R4: Without injection, `garb_pe` = {a, a and b} and `garb_tr` = {a, a and not b} (bit 1 is a, bit 0 is the product term), whatever the select.
- R5: With `inj_in` all zero, `fault` is 0 and `fault_map` is all zero for every input vector and both select values.
- R6: Any single set bit of `inj_in` raises `fault`, and `fault_map` then has exactly bit `chain*3 + gate` set, where chain 0 is Peres, chain 1 is TR, and index = `(chain*3+gate)*3 + line`.
- R7: An injection into the chain that is not selected still raises `fault`, but leaves `y_out` and the selected chain's garbage lines at their fault-free values.
- R8: Without injection, the xor of a chain's three outputs and two garbage lines equals a xor b xor c, since the ancillas are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 1 | First data bit (control line) |
| b_in | input | 1 | Second data bit |
| c_in | input | 1 | Third data bit |
| sel_tr | input | 1 | Function select: 0 Peres, 1 TR |
| inj_in | input | 18 | One bit per gate output line; a set bit flips that line |
| y_out | output | 3 | Selected function outputs {R, Q, P} |
| garb_pe | output | 2 | Garbage lines of the Peres chain |
| garb_tr | output | 2 | Garbage lines of the TR chain |
| fault | output | 1 | OR of all per-gate parity mismatches |
| fault_map | output | 6 | Per-gate parity mismatch, bit chain*3+gate |

## Verification
Both selects are run over all eight input vectors. The Peres and TR rows differ only where b is 1 or 0 and a is 1, so a swapped product term in the R line shows up at once. A pass with `c_in` held at zero reads the TR outputs as a subtractor, and the expected values come from integer subtraction. Every one of the eighteen single-line injections is then applied under every input and select. This separates detection by the right gate's checker from a fault that leaks into the selected outputs or into the other chain.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int PP_LINES  = 3;
    localparam int PP_GARB   = 2;
    localparam int PP_GATES  = 3;
    localparam int PP_CHAINS = 2;
    localparam int PP_INJ_CHAIN = PP_GATES * PP_LINES;
    localparam int PP_INJ    = PP_CHAINS * PP_INJ_CHAIN;
    localparam int PP_MAP    = PP_CHAINS * PP_GATES;

    typedef enum logic {
        FN_PERES = 1'b0,
        FN_TR    = 1'b1
    } pp_fn_e;
endpackage

// File: rtl/pp_dual_feynman.sv
module pp_dual_feynman
    import pp_pkg::*;
(
    input  logic                a,
    input  logic                b,
    input  logic                c,
    input  logic [PP_LINES-1:0] inj,
    output logic                p,
    output logic                q,
    output logic                r,
    output logic                err
);
    logic [PP_LINES-1:0] raw;

    always_comb begin
        raw = {a ^ c, a ^ b, a};
        {r, q, p} = raw ^ inj;
        err = (^{a, b, c}) ^ (^{r, q, p});
    end
endmodule

// File: rtl/pp_fredkin.sv
module pp_fredkin
    import pp_pkg::*;
(
    input  logic                ctl,
    input  logic                x,
    input  logic                y,
    input  logic [PP_LINES-1:0] inj,
    output logic                o_ctl,
    output logic                o_x,
    output logic                o_y,
    output logic                err
);
    logic [PP_LINES-1:0] raw;

    always_comb begin
        raw = ctl ? {x, y, ctl} : {y, x, ctl};
        {o_y, o_x, o_ctl} = raw ^ inj;
        err = (^{ctl, x, y}) ^ (^{o_y, o_x, o_ctl});
    end
endmodule

// File: rtl/pp_chain.sv
module pp_chain
    import pp_pkg::*;
#(
    parameter pp_fn_e FN = FN_PERES
) (
    input  logic                    a,
    input  logic                    b,
    input  logic                    c,
    input  logic [PP_INJ_CHAIN-1:0] inj,
    output logic [PP_LINES-1:0]     y,
    output logic [PP_GARB-1:0]      garb,
    output logic [PP_GATES-1:0]     err
);
    localparam logic ANCILLA = 1'b0;

    logic a_pass, ab_x, a_copy;
    logic x_pass, prod_t, prod_f;
    logic ctl2, third2;
    logic g2_p, g2_q, g2_r;

    // gate 0: split a, form a^b, duplicate a onto an ancilla
    pp_dual_feynman u_g0 (
        .a(a), .b(b), .c(ANCILLA), .inj(inj[0*PP_LINES +: PP_LINES]),
        .p(a_pass), .q(ab_x), .r(a_copy), .err(err[0])
    );

    // gate 1: controlled by a^b, recovers a&b and a&~b
    pp_fredkin u_g1 (
        .ctl(ab_x), .x(a_copy), .y(ANCILLA), .inj(inj[1*PP_LINES +: PP_LINES]),
        .o_ctl(x_pass), .o_x(prod_t), .o_y(prod_f), .err(err[1])
    );

    generate
        if (FN == FN_TR) begin : g_tr
            assign ctl2   = prod_f;
            assign third2 = prod_t;
        end else begin : g_peres
            assign ctl2   = prod_t;
            assign third2 = prod_f;
        end
    endgenerate

    // gate 2: product term xor c; the two products recombine to a
    pp_dual_feynman u_g2 (
        .a(ctl2), .b(c), .c(third2), .inj(inj[2*PP_LINES +: PP_LINES]),
        .p(g2_p), .q(g2_q), .r(g2_r), .err(err[2])
    );

    assign y    = {g2_q, x_pass, a_pass};
    assign garb = {g2_r, g2_p};
endmodule

// File: rtl/peres_tr_pp.sv
module peres_tr_pp
    import pp_pkg::*;
(
    input  logic               a_in,
    input  logic               b_in,
    input  logic               c_in,
    input  logic               sel_tr,
    input  logic [PP_INJ-1:0]  inj_in,
    output logic [PP_LINES-1:0] y_out,
    output logic [PP_GARB-1:0] garb_pe,
    output logic [PP_GARB-1:0] garb_tr,
    output logic               fault,
    output logic [PP_MAP-1:0]  fault_map
);
    logic [PP_LINES-1:0] chain_y [PP_CHAINS];
    logic [PP_GARB-1:0]  chain_g [PP_CHAINS];

    generate
        for (genvar k = 0; k < PP_CHAINS; k++) begin : g_chain
            pp_chain #(
                .FN((k == 0) ? FN_PERES : FN_TR)
            ) u_chain (
                .a(a_in), .b(b_in), .c(c_in),
                .inj(inj_in[k*PP_INJ_CHAIN +: PP_INJ_CHAIN]),
                .y(chain_y[k]),
                .garb(chain_g[k]),
                .err(fault_map[k*PP_GATES +: PP_GATES])
            );
        end
    endgenerate

    pp_fn_e fn_sel;
    assign fn_sel  = pp_fn_e'(sel_tr);
    assign y_out   = (fn_sel == FN_TR) ? chain_y[1] : chain_y[0];
    assign garb_pe = chain_g[0];
    assign garb_tr = chain_g[1];
    assign fault   = |fault_map;

    always_comb begin
        if (inj_in == '0) begin
            p_peres_map_r1: assert (chain_y[0] == {(a_in & b_in) ^ c_in, a_in ^ b_in, a_in})
                else $error("Peres chain mapping wrong");
            p_tr_map_r2: assert (chain_y[1] == {(a_in & ~b_in) ^ c_in, a_in ^ b_in, a_in})
                else $error("TR chain mapping wrong");
            p_quiet_flag_r5: assert (!fault)
                else $error("fault raised without injection");
            p_line_parity_r8: assert ((^{chain_y[0], chain_g[0]}) == (^{a_in, b_in, c_in}))
                else $error("Peres chain line parity broken");
        end
        if ($countones(inj_in) == 1) begin
            p_single_detect_r6: assert ($countones(fault_map) == 1)
                else $error("single injection not pinned to one gate");
        end
    end
endmodule

// File: tb/peres_tr_pp_test.sv
`timescale 1ns/1ps
module peres_tr_pp_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_in = 1'b0, b_in = 1'b0, c_in = 1'b0, sel_tr = 1'b0;
    logic [17:0] inj_in = '0;
    logic [2:0]  y_out;
    logic [1:0]  garb_pe, garb_tr;
    logic        fault;
    logic [5:0]  fault_map;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    peres_tr_pp uut (
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .sel_tr(sel_tr), .inj_in(inj_in),
        .y_out(y_out), .garb_pe(garb_pe), .garb_tr(garb_tr),
        .fault(fault), .fault_map(fault_map)
    );

    function automatic logic [2:0] ref_y(int s, int a, int b, int c);
        int r;
        r = (s == 0) ? ((a * b) % 2) : ((a * (1 - b)) % 2);
        r = (r + c) % 2;
        return 3'(r * 4 + ((a + b) % 2) * 2 + a);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(int s, int v, logic [17:0] inj);
        @(posedge clk);
        sel_tr = s[0];
        a_in = v[0]; b_in = v[1]; c_in = v[2];
        inj_in = inj;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state with all inputs low
        check("R1 idle y", y_out, 0);
        check("R5 idle fault", fault, 0);

        // fault-free sweep
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 8; v++) begin
                int a, b, c;
                a = v % 2; b = (v / 2) % 2; c = v / 4;
                drive(s, v, '0);
                check(s == 0 ? "R1 peres map" : "R2 tr map", y_out, ref_y(s, a, b, c));
                check("R4 garbage pe", garb_pe, a * 2 + a * b);
                check("R4 garbage tr", garb_tr, a * 2 + a * (1 - b));
                check("R5 fault flag", fault, 0);
                check("R5 fault map", fault_map, 0);
                check("R8 line parity", ^{y_out, (s == 0) ? garb_pe : garb_tr}, (a + b + c) % 2);
                if (s == 1 && c == 0) begin
                    int d;
                    d = b - a;
                    check("R3 difference", y_out[1], (d < 0) ? -d : d);
                    check("R3 borrow", y_out[2], (d < 0) ? 1 : 0);
                end
            end
        end

        // single-line injection sweep
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 8; v++) begin
                for (int idx = 0; idx < 18; idx++) begin
                    int a, b, c, ch, gt;
                    a = v % 2; b = (v / 2) % 2; c = v / 4;
                    ch = idx / 9;
                    gt = (idx % 9) / 3;
                    drive(s, v, 18'(1) << idx);
                    check("R6 fault flag", fault, 1);
                    check("R6 fault map", fault_map, 1 << (ch * 3 + gt));
                    if (ch != s) begin
                        check("R7 y untouched", y_out, ref_y(s, a, b, c));
                        if (s == 0)
                            check("R7 garbage pe untouched", garb_pe, a * 2 + a * b);
                        else
                            check("R7 garbage tr untouched", garb_tr, a * 2 + a * (1 - b));
                    end
                end
            end
        end

        drive(0, 0, '0);
        check("R5 flag clears", fault, 0);
        finish_run();
    end
endmodule